// File: doc/BRIEF.md
# Revision Protection Controller

This block guards a memory that is divided into design revisions. It stores a lock (write-protect) bit for each revision and a read-protect state. The read-protect state is either one bit for the whole memory or one bit per revision, chosen by a parameter. A command decoder feeds it one decoded command at a time, together with a revision index. One cycle later the block answers with a grant or a deny pulse. On the same clock edge it updates its protection bits.

Read protection only refuses readout and comparison of stored contents. Programming and erasing are still allowed. Clearing a lock takes two steps scoped to one revision: first an unlock command arms that revision, and then the next granted command must be an erase of that same revision. Any other granted command in between disarms it. A denied command changes nothing, not even the armed unlock.

Top module: `rev_protect_ctrl`

## Requirements
- R1: After synchronous reset, every lock bit and read-protect bit is cleared, no unlock is armed, and neither grant nor deny is asserted.
- R2: A cycle with cmd_valid high is answered in the next cycle by exactly one of grant or deny, each lasting one cycle. A cycle with cmd_valid low produces neither.
- R3: READ (op 0) and VERIFY (op 1) are denied when the read-protect state covering the named revision is set, and granted otherwise.
- R4: Read protection never blocks PROGRAM (op 2), revision erase (op 3) or full erase (op 7).
- R5: With PER_REV_READ=0, SET_READ_PROTECT (op 5) sets one bit that shows on every rp_vec bit. A revision erase leaves that bit set, and only a granted full erase (op 7) clears it.
- R6: With PER_REV_READ=1, SET_READ_PROTECT sets only the named revision's rp_vec bit. A granted revision erase clears only that revision's bit.
- R7: LOCK (op 4) sets the named revision's wp_vec bit. A locked revision denies PROGRAM and revision erase, and a full erase is denied while any lock is set.
- R8: UNLOCK (op 6) of a revision, followed by a revision erase of that same revision as the next granted command, is granted even when the revision is locked. The erase clears that revision's lock bit and its read-protect bit.
- R9: A granted command other than the matching erase cancels an armed unlock. This includes an UNLOCK of another revision and an erase of another revision. After that, an erase of the locked revision is denied.
- R10: A denied command changes neither rp_vec nor wp_vec and leaves an armed unlock in place.
- R11: LOCK, SET_READ_PROTECT and UNLOCK are always granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A decoded command is presented this cycle |
| cmd_op | input | 3 | Command code: 0 read, 1 verify, 2 program, 3 revision erase, 4 lock, 5 set read-protect, 6 unlock, 7 full erase |
| cmd_rev | input | $clog2(NUM_REV) | Revision index the command targets |
| grant | output | 1 | One-cycle pulse: the previous command was allowed |
| deny | output | 1 | One-cycle pulse: the previous command was refused |
| rp_vec | output | NUM_REV | Read-protect state as seen by each revision |
| wp_vec | output | NUM_REV | Lock bit of each revision |

## Verification
The bench drives the gating decision with a command sequence in which each operation meets a revision whose two bits are clear, read-protected only, locked only, or both. This shows that read gating follows only the read-protect bit and write gating follows only the lock bit. Unlock sequences are tried in three forms: immediately followed by the matching erase, interrupted by a granted read, and interrupted by an unlock of another revision. This separates correct disarming from a controller that remembers an unlock too long. A denied read placed between unlock and erase shows that refusals keep the armed state. A second instance in whole-device mode shows that a revision erase leaves the shared read-protect bit set and only a full erase clears it.

// File: rtl/revprot_pkg.sv
package revprot_pkg;

    typedef enum logic [2:0] {
        OP_READ      = 3'd0,
        OP_VERIFY    = 3'd1,
        OP_PROG      = 3'd2,
        OP_ERASE_REV = 3'd3,
        OP_LOCK      = 3'd4,
        OP_SET_RP    = 3'd5,
        OP_UNLOCK    = 3'd6,
        OP_ERASE_ALL = 3'd7
    } prot_op_e;

    // Outcome of one command: whether it is allowed and which bits it touches.
    typedef struct packed {
        logic allow;
        logic set_wp;
        logic set_rp;
        logic clr_rev;
        logic clr_all;
        logic arm;
    } prot_act_t;

    function automatic logic op_is_readout(prot_op_e op);
        return (op == OP_READ) || (op == OP_VERIFY);
    endfunction

    function automatic logic op_is_config(prot_op_e op);
        return (op == OP_LOCK) || (op == OP_SET_RP) || (op == OP_UNLOCK);
    endfunction

endpackage

// File: rtl/rev_prot_decide.sv
module rev_prot_decide
    import revprot_pkg::*;
#(
    parameter int NUM_REV = 4,
    parameter int REV_W   = $clog2(NUM_REV)
) (
    input  prot_op_e           op,
    input  logic [REV_W-1:0]   rev,
    input  logic [NUM_REV-1:0] rp_vec,
    input  logic [NUM_REV-1:0] wp_vec,
    input  logic               armed,
    input  logic [REV_W-1:0]   arm_rev,
    output prot_act_t          act
);

    logic unlock_hit;
    assign unlock_hit = armed && (arm_rev == rev);

    always_comb begin
        act = '0;
        case (op)
            OP_READ, OP_VERIFY: act.allow = !rp_vec[rev];
            OP_PROG:            act.allow = !wp_vec[rev];
            OP_ERASE_REV: begin
                act.allow   = !wp_vec[rev] || unlock_hit;
                act.clr_rev = act.allow;
            end
            OP_LOCK: begin
                act.allow  = 1'b1;
                act.set_wp = 1'b1;
            end
            OP_SET_RP: begin
                act.allow  = 1'b1;
                act.set_rp = 1'b1;
            end
            OP_UNLOCK: begin
                act.allow = 1'b1;
                act.arm   = 1'b1;
            end
            OP_ERASE_ALL: begin
                act.allow   = (wp_vec == '0);
                act.clr_all = act.allow;
            end
            default: act = '0;
        endcase
    end

endmodule

// File: rtl/rev_prot_store.sv
module rev_prot_store
    import revprot_pkg::*;
#(
    parameter int NUM_REV      = 4,
    parameter int REV_W        = $clog2(NUM_REV),
    parameter bit PER_REV_READ = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               upd,
    input  logic [REV_W-1:0]   rev,
    input  prot_act_t          act,
    output logic [NUM_REV-1:0] rp_vec,
    output logic [NUM_REV-1:0] wp_vec,
    output logic               armed,
    output logic [REV_W-1:0]   arm_rev
);

    logic apply;
    assign apply = upd && act.allow;

    // Lock bits, one per revision
    always_ff @(posedge clk) begin
        if (rst) begin
            wp_vec <= '0;
        end else if (apply) begin
            if (act.set_wp)  wp_vec[rev] <= 1'b1;
            if (act.clr_rev) wp_vec[rev] <= 1'b0;
            if (act.clr_all) wp_vec      <= '0;
        end
    end

    // Unlock arming: any granted command rewrites it, denied ones keep it
    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            arm_rev <= '0;
        end else if (apply) begin
            armed <= act.arm;
            if (act.arm) arm_rev <= rev;
        end
    end

    generate
        if (PER_REV_READ) begin : g_rp_per_rev
            logic [NUM_REV-1:0] rp_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    rp_q <= '0;
                end else if (apply) begin
                    if (act.set_rp)  rp_q[rev] <= 1'b1;
                    if (act.clr_rev) rp_q[rev] <= 1'b0;
                    if (act.clr_all) rp_q      <= '0;
                end
            end
            assign rp_vec = rp_q;
        end else begin : g_rp_global
            logic rp_g;
            always_ff @(posedge clk) begin
                if (rst) begin
                    rp_g <= 1'b0;
                end else if (apply) begin
                    if (act.set_rp)  rp_g <= 1'b1;
                    if (act.clr_all) rp_g <= 1'b0;
                end
            end
            assign rp_vec = {NUM_REV{rp_g}};

            // R5: the shared bit drops only through a granted full erase
            a_r5_global_clear_full_only: assert property (@(posedge clk) disable iff (rst)
                $fell(rp_g) |-> $past(upd && act.allow && act.clr_all));
        end
    endgenerate

    // R9: an erase of a locked revision only passes when that revision is armed
    a_r9_locked_erase_needs_arm: assert property (@(posedge clk) disable iff (rst)
        (upd && act.allow && act.clr_rev && wp_vec[rev]) |-> (armed && arm_rev == rev));

endmodule

// File: rtl/rev_protect_ctrl.sv
module rev_protect_ctrl
    import revprot_pkg::*;
#(
    parameter int NUM_REV      = 4,
    parameter bit PER_REV_READ = 1'b1,
    localparam int REV_W       = $clog2(NUM_REV)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [REV_W-1:0]   cmd_rev,
    output logic               grant,
    output logic               deny,
    output logic [NUM_REV-1:0] rp_vec,
    output logic [NUM_REV-1:0] wp_vec
);

    prot_op_e         op;
    prot_act_t        act;
    logic             armed;
    logic [REV_W-1:0] arm_rev;

    assign op = prot_op_e'(cmd_op);

    rev_prot_decide #(.NUM_REV(NUM_REV), .REV_W(REV_W)) u_decide (
        .op      (op),
        .rev     (cmd_rev),
        .rp_vec  (rp_vec),
        .wp_vec  (wp_vec),
        .armed   (armed),
        .arm_rev (arm_rev),
        .act     (act)
    );

    rev_prot_store #(.NUM_REV(NUM_REV), .REV_W(REV_W), .PER_REV_READ(PER_REV_READ)) u_store (
        .clk     (clk),
        .rst     (rst),
        .upd     (cmd_valid),
        .rev     (cmd_rev),
        .act     (act),
        .rp_vec  (rp_vec),
        .wp_vec  (wp_vec),
        .armed   (armed),
        .arm_rev (arm_rev)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant <= 1'b0;
            deny  <= 1'b0;
        end else begin
            grant <= cmd_valid &&  act.allow;
            deny  <= cmd_valid && !act.allow;
        end
    end

    a_r2_one_answer: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> (grant ^ deny));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> (!grant && !deny));

    a_r3_protected_read_denied: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op_is_readout(op) && rp_vec[cmd_rev]) |=> deny);

    a_r4_rp_no_write_block: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_PROG && !wp_vec[cmd_rev]) |=> grant);

    a_r7_locked_prog_denied: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_PROG && wp_vec[cmd_rev]) |=> deny);

    a_r10_deny_keeps_bits: assert property (@(posedge clk) disable iff (rst)
        deny |-> (wp_vec == $past(wp_vec) && rp_vec == $past(rp_vec)));

    a_r11_config_granted: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op_is_config(op)) |=> grant);

endmodule

// File: tb/rev_protect_ctrl_tb.sv
module rev_protect_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_rev = 2'd0;
    logic       grant, deny, grant_g, deny_g;
    logic [3:0] rp_vec, wp_vec, rp_g, wp_g;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rev_protect_ctrl #(.NUM_REV(4), .PER_REV_READ(1'b1)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_rev(cmd_rev),
        .grant(grant), .deny(deny), .rp_vec(rp_vec), .wp_vec(wp_vec)
    );

    rev_protect_ctrl #(.NUM_REV(4), .PER_REV_READ(1'b0)) dut_g (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_rev(cmd_rev),
        .grant(grant_g), .deny(deny_g), .rp_vec(rp_g), .wp_vec(wp_g)
    );

    // Row: {op[2:0], rev[1:0], expect_grant, expect_rp[3:0], expect_wp[3:0]}
    localparam logic [13:0] VEC [16] = '{
        {3'd0, 2'd0, 1'b1, 4'b0000, 4'b0000},  // R3 read, no protection
        {3'd5, 2'd1, 1'b1, 4'b0010, 4'b0000},  // R6 R11 set read-protect rev1
        {3'd0, 2'd1, 1'b0, 4'b0010, 4'b0000},  // R3 read of protected rev1
        {3'd1, 2'd1, 1'b0, 4'b0010, 4'b0000},  // R3 verify of protected rev1
        {3'd0, 2'd2, 1'b1, 4'b0010, 4'b0000},  // R6 other revision readable
        {3'd2, 2'd1, 1'b1, 4'b0010, 4'b0000},  // R4 program despite read-protect
        {3'd4, 2'd2, 1'b1, 4'b0010, 4'b0100},  // R7 R11 lock rev2
        {3'd2, 2'd2, 1'b0, 4'b0010, 4'b0100},  // R7 program locked
        {3'd3, 2'd2, 1'b0, 4'b0010, 4'b0100},  // R7 erase locked
        {3'd7, 2'd0, 1'b0, 4'b0010, 4'b0100},  // R7 full erase with a lock
        {3'd3, 2'd1, 1'b1, 4'b0000, 4'b0100},  // R4 R6 erase rev1 clears rp
        {3'd6, 2'd2, 1'b1, 4'b0000, 4'b0100},  // R11 unlock rev2
        {3'd0, 2'd0, 1'b1, 4'b0000, 4'b0100},  // R9 granted read disarms
        {3'd3, 2'd2, 1'b0, 4'b0000, 4'b0100},  // R9 erase denied after disarm
        {3'd6, 2'd2, 1'b1, 4'b0000, 4'b0100},  // R8 unlock rev2 again
        {3'd3, 2'd2, 1'b1, 4'b0000, 4'b0000}   // R8 erase clears lock
    };

    task automatic check4(string tag, string what, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic issue(logic [2:0] op, logic [1:0] rev);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_rev   = rev;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run(string tag, logic [2:0] op, logic [1:0] rev, logic exp_grant);
        issue(op, rev);
        check4(tag, "grant/deny", {2'b00, grant, deny}, {2'b00, exp_grant, !exp_grant});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check4("R1", "rp_vec", rp_vec, 4'b0000);
        check4("R1", "wp_vec", wp_vec, 4'b0000);
        check4("R1", "grant/deny", {2'b00, grant, deny}, 4'b0000);

        // Table walk on the per-revision instance
        for (int i = 0; i < 16; i++) begin
            logic [13:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("table row %0d", i);
            run(tag, v[13:11], v[10:9], v[8]);
            check4(tag, "rp_vec", rp_vec, v[7:4]);
            check4(tag, "wp_vec", wp_vec, v[3:0]);
        end

        // R2: idle cycle gives no response
        @(negedge clk);
        check4("R2", "idle grant/deny", {2'b00, grant, deny}, 4'b0000);

        // R10: denied read between unlock and erase keeps the armed state
        run("R10", 3'd4, 2'd3, 1'b1);
        run("R10", 3'd5, 2'd3, 1'b1);
        run("R10", 3'd6, 2'd3, 1'b1);
        run("R10", 3'd0, 2'd3, 1'b0);
        check4("R10", "rp_vec after deny", rp_vec, 4'b1000);
        check4("R10", "wp_vec after deny", wp_vec, 4'b1000);
        run("R10", 3'd3, 2'd3, 1'b1);
        check4("R8", "rp_vec after unlock erase", rp_vec, 4'b0000);
        check4("R8", "wp_vec after unlock erase", wp_vec, 4'b0000);

        // R9: unlock of another revision replaces the arming
        run("R9", 3'd4, 2'd0, 1'b1);
        run("R9", 3'd6, 2'd0, 1'b1);
        run("R9", 3'd6, 2'd1, 1'b1);
        run("R9", 3'd3, 2'd0, 1'b0);
        // R9: granted erase of another revision also disarms
        run("R9", 3'd6, 2'd0, 1'b1);
        run("R9", 3'd3, 2'd2, 1'b1);
        run("R9", 3'd3, 2'd0, 1'b0);
        check4("R9", "wp_vec", wp_vec, 4'b0001);

        // R4: full erase is not blocked by read-protect once no lock remains
        run("R4", 3'd6, 2'd0, 1'b1);
        run("R4", 3'd3, 2'd0, 1'b1);
        run("R4", 3'd5, 2'd2, 1'b1);
        run("R4", 3'd7, 2'd0, 1'b1);
        check4("R4", "rp_vec after full erase", rp_vec, 4'b0000);

        // R5: whole-device read-protect on the second instance
        do_reset();
        issue(3'd5, 2'd2);
        check4("R5", "global rp after set", rp_g, 4'b1111);
        issue(3'd3, 2'd2);
        check4("R5", "erase rev grant/deny", {2'b00, grant_g, deny_g}, 4'b0010);
        check4("R5", "global rp after revision erase", rp_g, 4'b1111);
        issue(3'd0, 2'd0);
        check4("R5", "read rev0 grant/deny", {2'b00, grant_g, deny_g}, 4'b0001);
        issue(3'd7, 2'd0);
        check4("R5", "full erase grant/deny", {2'b00, grant_g, deny_g}, 4'b0010);
        check4("R5", "global rp after full erase", rp_g, 4'b0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule